// File: doc/BRIEF.md
# Software-Selectable Clock Rate Switcher

This block takes one free-running oscillator and produces the clock for an 8-bit processor. It divides the oscillator into two candidate clocks, a base rate and a double rate at exactly twice the base, and passes one of them to the processor through a glitch-free multiplexer. A one-bit speed register chooses the rate. Software sets that register by writing to a single fixed I/O port, and a board strap gives its value after reset.

An active-low slow-down input, normally wired to the chip select of a slow peripheral, forces the base rate for as long as it is low. While it is held, the processor can reach that peripheral at the base rate. When it is released, the clock goes back to the rate in the speed register. A status output reports the rate in effect, with the override already applied.

Top module: `clk_rate_switch`

## Requirements
- R1: Both candidate clocks come from one counter on `osc_clk`. The double-rate clock has a period of 2 oscillator cycles and the base-rate clock a period of 4, each with 50% duty.
- R2: An I/O write (`io_m` = 1) to address 85 decimal with data bit 0 = 1 selects the double rate. The same write with data bit 0 = 0 selects the base rate.
- R3: Data bits 7:1 of a control write have no effect on the selected rate.
- R4: A write to any other 8-bit address, or a memory write (`io_m` = 0) to address 85, leaves the speed register unchanged. All 8 address bits are compared.
- R5: A write takes effect only on the rising edge of `io_wr_n`. Holding the strobe low changes nothing.
- R6: After reset the speed register takes the value of `boot_fast`: 0 gives the base rate and 1 gives the double rate.
- R7: While `slow_req_n` is low, the base rate is forced whatever the register holds. Control writes made during the override are still stored and apply once `slow_req_n` returns high.
- R8: The multiplexer changes source only while both candidate clocks are low. It never enables both sources at once, and a base-rate high phase is never shortened.
- R9: `rate_fast` (1 = double rate, 0 = base rate) shows the effective rate within 8 oscillator cycles of a change on `slow_req_n` or of the end of a control write.
- R10: While `rst_n` is low, `cpu_clk` and `rate_fast` are 0. The release of `rst_n` is synchronised to `osc_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator, four times the base output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_fast | input | 1 | Strap giving the rate after reset (1 = double rate) |
| slow_req_n | input | 1 | Active-low asynchronous request that forces the base rate |
| io_m | input | 1 | Bus status: 1 = I/O cycle, 0 = memory cycle |
| io_wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Port address |
| data | input | 8 | Write data. Bit 0 is the speed bit |
| cpu_clk | output | 1 | Clock to the processor |
| rate_fast | output | 1 | Effective rate: 1 = double rate, 0 = base rate |

## Verification
The assertions check on every cycle the properties the clock multiplexer must always keep. Source gates change only while both divided clocks are low, the two gates are never on together, a base-rate high phase lasts its full two cycles, and the output is low when no gate is on. They also check that an active override yields the base rate, that an unforced set register yields the double rate, and that a strobe edge to a foreign port leaves the register untouched. The bench's scenarios alone can show the measured output periods, the strap value after reset, the rule that data bits above bit 0 and memory cycles are ignored, the fact that a held-low strobe has no effect, and the return to a value written while the override was active.

// File: rtl/rate_pkg.sv
package rate_pkg;

  // Speed selection held by the control register
  typedef enum logic {
    RATE_BASE   = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;

endpackage

// File: rtl/rate_sync.sv
// Multi-stage synchroniser with asynchronous reset to a chosen level.
module rate_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end else begin : g_single
      always_comb chain_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rate_port_latch.sv
// Decodes the control port write and holds the speed selection.
module rate_port_latch
  import rate_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_PORT = 8'd85,
  parameter int                SEL_BIT   = 0,
  parameter int                STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_fast,
  input  logic              io_m,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output rate_e             sel_q,
  output logic              wr_rise,
  output logic              port_hit,
  output logic              boot_done
);

  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << SEL_BIT;

  logic  wr_s;
  logic  wr_prev_q;
  logic  boot_d;
  rate_e sel_d;
  logic  data_sel;

  rate_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_wr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (io_wr_n),
    .q     (wr_s)
  );

  always_comb begin
    wr_rise  = wr_s & ~wr_prev_q;
    port_hit = io_m & (addr == CTRL_PORT);
    data_sel = |(data & SEL_MASK);
  end

  always_comb begin
    sel_d  = sel_q;
    boot_d = 1'b1;
    if (!boot_done) begin
      sel_d = boot_fast ? RATE_DOUBLE : RATE_BASE;
    end else if (wr_rise && port_hit) begin
      sel_d = data_sel ? RATE_DOUBLE : RATE_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      boot_done <= 1'b0;
      sel_q     <= RATE_BASE;
    end else begin
      wr_prev_q <= wr_s;
      boot_done <= boot_d;
      sel_q     <= sel_d;
    end
  end

endmodule

// File: rtl/rate_divider.sv
// Free-running divider; two adjacent bits give clocks in a 2:1 ratio.
module rate_divider #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic fast_ph,
  output logic slow_ph,
  output logic fast_nx,
  output logic slow_nx,
  output logic wrap_nx
);

  localparam int FAST_BIT = DIV_W - 2;
  localparam int SLOW_BIT = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d   = cnt_q + DIV_W'(1);
    wrap_nx = (cnt_d == '0);
    fast_nx = cnt_d[FAST_BIT];
    slow_nx = cnt_d[SLOW_BIT];
    fast_ph = cnt_q[FAST_BIT];
    slow_ph = cnt_q[SLOW_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rate_clock_mux.sv
// Glitch-free selection: each source gate moves only at the common low
// point, and only once the other source gate is already off.
module rate_clock_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic want_fast,
  input  logic fast_nx,
  input  logic slow_nx,
  input  logic wrap_nx,
  output logic cpu_clk,
  output logic gate_f,
  output logic gate_s
);

  logic gate_f_d;
  logic gate_s_d;
  logic clk_d;

  always_comb begin
    gate_f_d = gate_f;
    gate_s_d = gate_s;
    if (wrap_nx) begin
      gate_f_d = want_fast  & ~gate_s;
      gate_s_d = ~want_fast & ~gate_f;
    end
    clk_d = (fast_nx & gate_f_d) | (slow_nx & gate_s_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_f  <= 1'b0;
      gate_s  <= 1'b0;
      cpu_clk <= 1'b0;
    end else begin
      gate_f  <= gate_f_d;
      gate_s  <= gate_s_d;
      cpu_clk <= clk_d;
    end
  end

endmodule

// File: rtl/clk_rate_switch.sv
module clk_rate_switch
  import rate_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_PORT   = 8'd85,
  parameter int                SEL_BIT     = 0,
  parameter int                SYNC_STAGES = 2,
  parameter int                DIV_W       = 2
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              boot_fast,
  input  logic              slow_req_n,
  input  logic              io_m,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cpu_clk,
  output logic              rate_fast
);

  logic  rst_sync_n;
  logic  slow_sync_n;
  rate_e latch_q;
  logic  wr_rise;
  logic  port_hit;
  logic  boot_done;
  logic  fast_ph;
  logic  slow_ph;
  logic  fast_nx;
  logic  slow_nx;
  logic  wrap_nx;
  logic  gate_f;
  logic  gate_s;
  logic  eff_fast;

  // Reset: asserted at once, released on the oscillator
  rate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  rate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_slow_sync (
    .clk   (osc_clk),
    .rst_n (rst_sync_n),
    .d     (slow_req_n),
    .q     (slow_sync_n)
  );

  rate_port_latch #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_PORT (CTRL_PORT),
    .SEL_BIT   (SEL_BIT),
    .STAGES    (SYNC_STAGES)
  ) u_latch (
    .clk       (osc_clk),
    .rst_n     (rst_sync_n),
    .boot_fast (boot_fast),
    .io_m      (io_m),
    .io_wr_n   (io_wr_n),
    .addr      (addr),
    .data      (data),
    .sel_q     (latch_q),
    .wr_rise   (wr_rise),
    .port_hit  (port_hit),
    .boot_done (boot_done)
  );

  rate_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (osc_clk),
    .rst_n   (rst_sync_n),
    .fast_ph (fast_ph),
    .slow_ph (slow_ph),
    .fast_nx (fast_nx),
    .slow_nx (slow_nx),
    .wrap_nx (wrap_nx)
  );

  always_comb eff_fast = slow_sync_n & (latch_q == RATE_DOUBLE);

  rate_clock_mux u_mux (
    .clk       (osc_clk),
    .rst_n     (rst_sync_n),
    .want_fast (eff_fast),
    .fast_nx   (fast_nx),
    .slow_nx   (slow_nx),
    .wrap_nx   (wrap_nx),
    .cpu_clk   (cpu_clk),
    .gate_f    (gate_f),
    .gate_s    (gate_s)
  );

  always_ff @(posedge osc_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rate_fast <= 1'b0;
    else             rate_fast <= eff_fast;
  end

endmodule

// File: rtl/rate_switch_chk.sv
module rate_switch_chk
  import rate_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  slow_sync_n,
  input rate_e latch_q,
  input logic  wr_rise,
  input logic  port_hit,
  input logic  boot_done,
  input logic  fast_ph,
  input logic  slow_ph,
  input logic  gate_f,
  input logic  gate_s,
  input logic  cpu_clk,
  input logic  rate_fast
);

  AST_GATE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gate_f) || !$stable(gate_s)) |-> (!fast_ph && !slow_ph)); // R8

  AST_GATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_f && gate_s)); // R8

  AST_SLOW_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s && $rose(cpu_clk)) |=> cpu_clk); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_f && !gate_s) |-> !cpu_clk); // R8

  AST_OVERRIDE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_sync_n |=> !rate_fast); // R7

  AST_FOLLOW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sync_n && latch_q == RATE_DOUBLE) |=> rate_fast); // R9

  AST_FOREIGN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && wr_rise && !port_hit) |=> $stable(latch_q)); // R4

endmodule

bind clk_rate_switch rate_switch_chk u_chk (
  .clk         (osc_clk),
  .rst_n       (rst_sync_n),
  .slow_sync_n (slow_sync_n),
  .latch_q     (latch_q),
  .wr_rise     (wr_rise),
  .port_hit    (port_hit),
  .boot_done   (boot_done),
  .fast_ph     (fast_ph),
  .slow_ph     (slow_ph),
  .gate_f      (gate_f),
  .gate_s      (gate_s),
  .cpu_clk     (cpu_clk),
  .rate_fast   (rate_fast)
);

// File: tb/clk_rate_switch_tb.sv
module clk_rate_switch_tb;

  logic       osc_clk = 1'b0;
  logic       rst_n;
  logic       boot_fast;
  logic       slow_req_n;
  logic       io_m;
  logic       io_wr_n;
  logic [7:0] addr;
  logic [7:0] data;
  logic       cpu_clk;
  logic       rate_fast;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 osc_clk = ~osc_clk;

  clk_rate_switch u_dut (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .boot_fast  (boot_fast),
    .slow_req_n (slow_req_n),
    .io_m       (io_m),
    .io_wr_n    (io_wr_n),
    .addr       (addr),
    .data       (data),
    .cpu_clk    (cpu_clk),
    .rate_fast  (rate_fast)
  );

  // vector: {io_m, addr[7:0], data[7:0], slow_req_n, expected rate_fast}
  localparam int NVEC = 10;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 8'd85,  8'h01, 1'b1, 1'b1},  // R2 select double
    {1'b1, 8'd84,  8'h00, 1'b1, 1'b1},  // R4 other port ignored
    {1'b0, 8'd85,  8'h00, 1'b1, 1'b1},  // R4 memory write ignored
    {1'b1, 8'd85,  8'hFE, 1'b1, 1'b0},  // R3 bit0 = 0 wins
    {1'b1, 8'd85,  8'h03, 1'b1, 1'b1},  // R3 upper bits ignored
    {1'b1, 8'd86,  8'h00, 1'b0, 1'b0},  // R7 override forces base
    {1'b1, 8'd213, 8'h00, 1'b1, 1'b1},  // R4 full address compare
    {1'b1, 8'd85,  8'h00, 1'b0, 1'b0},  // R7 override with write 0
    {1'b1, 8'd85,  8'h01, 1'b0, 1'b0},  // R7 write 1 under override
    {1'b1, 8'd0,   8'h00, 1'b1, 1'b1}   // R7 stored value applies
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  // Oscillator cycles between two rising edges of cpu_clk
  task automatic measure(output int period);
    logic prev;
    int   cnt;
    period = 0;
    prev = cpu_clk;
    cnt  = 0;
    while (!(cpu_clk && !prev) && cnt < 40) begin
      prev = cpu_clk; @(negedge osc_clk); cnt++;
    end
    prev = cpu_clk;
    @(negedge osc_clk);
    cnt = 1;
    while (!(cpu_clk && !prev) && cnt < 40) begin
      prev = cpu_clk; @(negedge osc_clk); cnt++;
    end
    period = cnt;
  endtask

  task automatic bus_write(input logic m, input logic [7:0] a, input logic [7:0] d);
    io_m = m; addr = a; data = d;
    wait_cyc(2);
    io_wr_n = 1'b0;
    wait_cyc(3);
    io_wr_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic do_reset(input logic strap);
    int p;
    @(negedge osc_clk);
    rst_n = 1'b0; boot_fast = strap;
    wait_cyc(5);
    chk("R10 cpu_clk low in reset", int'(cpu_clk), 0);
    chk("R10 rate_fast low in reset", int'(rate_fast), 0);
    rst_n = 1'b1;
    wait_cyc(30);
    chk("R6 strap rate", int'(rate_fast), int'(strap));
    measure(p);
    chk("R1 period after reset", p, strap ? 2 : 4);
  endtask

  always @(posedge osc_clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p;
    rst_n = 1'b0; boot_fast = 1'b0; slow_req_n = 1'b1;
    io_m = 1'b0; io_wr_n = 1'b1; addr = '0; data = '0;

    do_reset(1'b0);

    for (int i = 0; i < NVEC; i++) begin
      slow_req_n = VEC[i][1];
      bus_write(VEC[i][18], VEC[i][17:10], VEC[i][9:2]);
      wait_cyc(20);
      chk($sformatf("R2/R3/R4/R7 vector %0d rate", i), int'(rate_fast), int'(VEC[i][0]));
      measure(p);
      chk($sformatf("R1/R8 vector %0d period", i), p, VEC[i][0] ? 2 : 4);
    end

    // R5: strobe held low does nothing until it rises
    bus_write(1'b1, 8'd85, 8'h00);
    wait_cyc(20);
    io_m = 1'b1; addr = 8'd85; data = 8'h01;
    wait_cyc(2);
    io_wr_n = 1'b0;
    wait_cyc(20);
    chk("R5 held strobe no effect", int'(rate_fast), 0);
    io_wr_n = 1'b1;
    wait_cyc(8);
    chk("R9 R5 rate after strobe rise", int'(rate_fast), 1);

    // R9: override latency
    slow_req_n = 1'b0;
    wait_cyc(6);
    chk("R9 override seen", int'(rate_fast), 0);
    slow_req_n = 1'b1;
    wait_cyc(6);
    chk("R9 override released", int'(rate_fast), 1);

    // R6: strap high, then reset mid-run back to strap low
    do_reset(1'b1);
    do_reset(1'b0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule